// File: doc/BRIEF.md
# Fixed-Point Arithmetic and Logic Unit

A one-cycle 16-bit arithmetic and logic unit for a signal-processing datapath. Each enabled cycle it takes two operands, a 4-bit operation code, a carry input, a bit index and a saturation enable. The chosen operation completes at the next clock edge. The result and four status flags (zero, negative, carry, overflow) are held in registers.

Two kinds of operation change only the flags and leave the result register as it was: compare and bit test. Multiword add and subtract are built by feeding the carry flag of one operation back as the carry input of the next. Unsigned division uses non-restoring division. A start operation loads the dividend and clears a partial remainder register. Each later step then produces one quotient bit. A quotient-sign flag steers each step between subtracting and adding the divisor.

Top module: `dsp_alu`

## Requirements
- R1: After reset, `result`, `div_rem`, `div_qsign` and all four flags are 0.
- R2: Op 0 writes `a+b` and op 1 writes `a+b+carry_in` to `result` at the clock edge where `op_en` is high. `flag_c` is the carry out of bit 15.
- R3: Op 2 writes `a+~b+1` and op 3 writes `a+~b+carry_in`. `flag_c` is the carry out of bit 15, so 1 means no borrow, and it can be chained into op 3.
- R4: For ops 0 to 3, `flag_v` is set on signed two's-complement overflow. For every operation that writes `result`, `flag_n` equals bit 15 of the new result and `flag_z` is set when the new result is 0.
- R5: Op 4 writes `a&b`, op 5 writes `a|b`, op 6 writes `a^b`, op 7 writes `~a` and op 15 writes `a`. Each of these clears `flag_c` and `flag_v`.
- R6: Ops 8, 9 and 10 write `a` with bit `bit_sel` set, cleared or inverted, respectively. Each clears `flag_c` and `flag_v`.
- R7: Op 11 (bit test) sets `flag_z` when bit `bit_sel` of `a` is 0 and clears it otherwise. It clears `flag_n`, `flag_c` and `flag_v` and leaves `result` unchanged.
- R8: Op 12 (compare) sets the flags exactly as op 2 would and leaves `result` unchanged.
- R9: Op 13 loads `a` into `result` and clears the remainder and `div_qsign`. Each op 14 then runs one non-restoring step with divisor `b`. After op 13 and 16 op-14 steps, `result` is the unsigned quotient. `div_rem` plus `b` (when `div_qsign` is 1) equals the remainder, modulo 2^16. Ops 13 and 14 leave the four flags unchanged.
- R10: With `sat_en` high, an overflowing op 0 to 3 writes 0x7FFF when `a` is non-negative and 0x8000 when `a` is negative. `flag_v` is still set.
- R11: While `op_en` is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Execute the operation this cycle |
| op | input | 4 | Operation code |
| a | input | 16 | First operand; dividend for op 13 |
| b | input | 16 | Second operand; divisor for op 14 |
| carry_in | input | 1 | Carry for ops 1 and 3 |
| bit_sel | input | 4 | Bit index for ops 8 to 11 |
| sat_en | input | 1 | Clamp overflowing arithmetic results |
| result | output | 16 | Result register |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| div_rem | output | 16 | Partial remainder of the division |
| div_qsign | output | 1 | Quotient-sign flag (remainder negative) |

## Verification
The adder is tested with several operand patterns, each aimed at a different fault:
- An all-ones plus one operand wraps to zero, which separates the carry flag from the zero flag.
- Operands near the sign boundary separate the overflow flag from the carry flag.
- A 32-bit add and a 32-bit subtract split into word pairs show whether the carry is chained in the correct sense for each.

Bit operations are run at the lowest, a middle and the highest index, which exposes faults in the index decode. The divider runs full 16-step divisions on these cases:
- a small divisor;
- divisor one;
- divisor equal to the dividend;
- a divisor larger than the dividend.

Together these cover both signs of the final remainder, so they exercise the add branch of the step as well as the subtract branch.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDC = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBC = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_NOT  = 4'd7,
      OP_BSET = 4'd8,
      OP_BCLR = 4'd9,
      OP_BTGL = 4'd10,
      OP_BTST = 4'd11,
      OP_CMP  = 4'd12,
      OP_DIVS = 4'd13,
      OP_DIVQ = 4'd14,
      OP_PASS = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic z;
      logic n;
      logic c;
      logic v;
   } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W           = 16,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   input  logic         use_cin,
   input  logic         sat_en,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);
   localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] b_eff;
   logic         c_eff;
   logic [W:0]   wide;
   logic [W-1:0] raw;

   assign b_eff = sub ? ~b : b;
   assign c_eff = use_cin ? cin : sub;
   assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
   assign raw   = wide[W-1:0];
   assign cout  = wide[W];
   assign ovf   = (a[W-1] == b_eff[W-1]) && (raw[W-1] != a[W-1]);

   generate
      if (SAT_SUPPORT) begin : g_sat
         assign sum = (sat_en && ovf) ? (a[W-1] ? NEG_MIN : POS_MAX) : raw;
      end else begin : g_nosat
         logic unused_sat;
         assign unused_sat = sat_en;
         assign sum = raw;
      end
   endgenerate
endmodule

// File: rtl/alu_logic_bits.sv
module alu_logic_bits
   import dsp_alu_pkg::*;
#(
   parameter int W    = 16,
   parameter int BP_W = $clog2(W)
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic [BP_W-1:0] bit_sel,
   output logic [W-1:0]   res,
   output logic           bit_val
);
   logic [W-1:0] mask;

   generate
      for (genvar i = 0; i < W; i++) begin : g_mask
         assign mask[i] = (bit_sel == BP_W'(i));
      end
   endgenerate

   assign bit_val = |(a & mask);

   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_NOT:  res = ~a;
         OP_BSET: res = a | mask;
         OP_BCLR: res = a & ~mask;
         OP_BTGL: res = a ^ mask;
         default: res = a;
      endcase
   end
endmodule

// File: rtl/alu_divstep.sv
module alu_divstep #(
   parameter int W = 16
) (
   input  logic [W:0]   rem_in,
   input  logic [W-1:0] low_in,
   input  logic         qs_in,
   input  logic [W-1:0] divisor,
   output logic [W:0]   rem_out,
   output logic [W-1:0] low_out,
   output logic         qs_out
);
   localparam int RW = W + 2;

   logic [RW-1:0] shifted;
   logic [RW-1:0] dext;
   logic [RW-1:0] diff;

   assign shifted = {rem_in, low_in[W-1]};
   assign dext    = {2'b00, divisor};
   assign diff    = qs_in ? (shifted + dext) : (shifted - dext);
   assign qs_out  = diff[RW-1];
   assign rem_out = diff[W:0];
   assign low_out = {low_in[W-2:0], ~diff[RW-1]};
endmodule

// File: rtl/dsp_alu.sv
module dsp_alu
   import dsp_alu_pkg::*;
#(
   parameter int W           = 16,
   parameter bit SAT_SUPPORT = 1'b1,
   localparam int BP_W       = $clog2(W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_en,
   input  logic [3:0]      op,
   input  logic [W-1:0]    a,
   input  logic [W-1:0]    b,
   input  logic            carry_in,
   input  logic [BP_W-1:0] bit_sel,
   input  logic            sat_en,
   output logic [W-1:0]    result,
   output logic            flag_z,
   output logic            flag_n,
   output logic            flag_c,
   output logic            flag_v,
   output logic [W-1:0]    div_rem,
   output logic            div_qsign
);
   generate
      if (W < 4) begin : g_bad_width
         $error("dsp_alu: W must be at least 4");
      end
      if ((1 << BP_W) != W) begin : g_bad_pow2
         $error("dsp_alu: W must be a power of two");
      end
   endgenerate

   alu_op_e    op_e;
   logic [W-1:0] as_sum, lg_res, dv_low;
   logic       as_cout, as_ovf, as_sub, as_usec, lg_bit, dv_qs;
   logic [W:0] dv_rem;

   logic [W-1:0] res_q, res_d;
   alu_flags_t   flg_q, flg_d;
   logic [W:0]   rem_q, rem_d;
   logic         qs_q, qs_d;

   assign op_e    = alu_op_e'(op);
   assign as_sub  = (op_e == OP_SUB) || (op_e == OP_SUBC) || (op_e == OP_CMP);
   assign as_usec = (op_e == OP_ADDC) || (op_e == OP_SUBC);

   alu_addsub #(.W(W), .SAT_SUPPORT(SAT_SUPPORT)) u_addsub (
      .a(a), .b(b), .cin(carry_in), .sub(as_sub), .use_cin(as_usec),
      .sat_en(sat_en && (op_e != OP_CMP)),
      .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
   );

   alu_logic_bits #(.W(W), .BP_W(BP_W)) u_logic (
      .op(op_e), .a(a), .b(b), .bit_sel(bit_sel),
      .res(lg_res), .bit_val(lg_bit)
   );

   alu_divstep #(.W(W)) u_div (
      .rem_in(rem_q), .low_in(res_q), .qs_in(qs_q), .divisor(b),
      .rem_out(dv_rem), .low_out(dv_low), .qs_out(dv_qs)
   );

   always_comb begin
      res_d = res_q;
      flg_d = flg_q;
      rem_d = rem_q;
      qs_d  = qs_q;
      unique case (op_e)
         OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
            res_d = as_sum;
            flg_d = '{z: (as_sum == '0), n: as_sum[W-1], c: as_cout, v: as_ovf};
         end
         OP_CMP: begin
            flg_d = '{z: (as_sum == '0), n: as_sum[W-1], c: as_cout, v: as_ovf};
         end
         OP_BTST: begin
            flg_d = '{z: ~lg_bit, n: 1'b0, c: 1'b0, v: 1'b0};
         end
         OP_DIVS: begin
            res_d = a;
            rem_d = '0;
            qs_d  = 1'b0;
         end
         OP_DIVQ: begin
            res_d = dv_low;
            rem_d = dv_rem;
            qs_d  = dv_qs;
         end
         default: begin
            res_d = lg_res;
            flg_d = '{z: (lg_res == '0), n: lg_res[W-1], c: 1'b0, v: 1'b0};
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
         flg_q <= '0;
         rem_q <= '0;
         qs_q  <= 1'b0;
      end else if (op_en) begin
         res_q <= res_d;
         flg_q <= flg_d;
         rem_q <= rem_d;
         qs_q  <= qs_d;
      end
   end

   assign result    = res_q;
   assign flag_z    = flg_q.z;
   assign flag_n    = flg_q.n;
   assign flag_c    = flg_q.c;
   assign flag_v    = flg_q.v;
   assign div_rem   = rem_q[W-1:0];
   assign div_qsign = qs_q;
endmodule

// File: rtl/dsp_alu_chk.sv
module dsp_alu_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_en,
   input logic [3:0]   op,
   input logic         sat_en,
   input logic [W-1:0] result,
   input logic         flag_z,
   input logic         flag_n,
   input logic         flag_c,
   input logic         flag_v,
   input logic [W-1:0] div_rem,
   input logic         div_qsign
);
   localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

   logic writes_plain;
   assign writes_plain = (op <= 4'd10) || (op == 4'd15);

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> $stable({result, flag_z, flag_n, flag_c, flag_v, div_rem, div_qsign})); // R11
   AST_TEST_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op == 4'd11) |=> $stable(result)); // R7
   AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op == 4'd12) |=> $stable(result)); // R8
   AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op >= 4'd4 && op <= 4'd10) |=> (!flag_c && !flag_v)); // R5
   AST_ZN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && writes_plain) |=> (flag_z == (result == '0) && flag_n == result[W-1])); // R4
   AST_DIV_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && (op == 4'd13 || op == 4'd14)) |=> $stable({flag_z, flag_n, flag_c, flag_v})); // R9
   AST_DIV_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && op == 4'd13) |=> (div_rem == '0 && !div_qsign)); // R9
   AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      (op_en && sat_en && op <= 4'd3) |=> (!flag_v || result == POS_MAX || result == NEG_MIN)); // R10
endmodule

bind dsp_alu dsp_alu_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .sat_en(sat_en),
   .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
   .flag_v(flag_v), .div_rem(div_rem), .div_qsign(div_qsign)
);

// File: tb/dsp_alu_tb.sv
module dsp_alu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_en = 1'b0;
   logic [3:0]  op = '0;
   logic [15:0] a = '0, b = '0;
   logic        carry_in = 1'b0;
   logic [3:0]  bit_sel = '0;
   logic        sat_en = 1'b0;
   logic [15:0] result, div_rem;
   logic        flag_z, flag_n, flag_c, flag_v, div_qsign;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   dsp_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .a(a), .b(b),
      .carry_in(carry_in), .bit_sel(bit_sel), .sat_en(sat_en),
      .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
      .flag_v(flag_v), .div_rem(div_rem), .div_qsign(div_qsign)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] o, input logic [15:0] x, input logic [15:0] y,
                      input logic ci, input logic [3:0] bs, input logic se);
      @(negedge clk);
      op = o; a = x; b = y; carry_in = ci; bit_sel = bs; sat_en = se; op_en = 1'b1;
      @(negedge clk);
      op_en = 1'b0;
   endtask

   function automatic logic [4:0] arith_ref(input logic [15:0] x, input logic [15:0] y,
                                            input logic sub, input logic ci,
                                            output logic [15:0] r);
      logic [16:0] w;
      logic [15:0] ye;
      logic v;
      ye = sub ? ~y : y;
      w  = {1'b0, x} + {1'b0, ye} + {16'd0, ci};
      r  = w[15:0];
      v  = (x[15] == ye[15]) && (r[15] != x[15]);
      return {1'b0, (r == 16'd0), r[15], w[16], v};
   endfunction

   task automatic t_reset();
      chk("R1 result", {16'd0, result}, 32'd0);
      chk("R1 flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'd0);
      chk("R1 remainder", {15'd0, div_qsign, div_rem}, 32'd0);
   endtask

   task automatic t_add(input logic [15:0] x, input logic [15:0] y);
      logic [15:0] r; logic [4:0] f;
      f = arith_ref(x, y, 1'b0, 1'b0, r);
      run(4'd0, x, y, 1'b0, 4'd0, 1'b0);
      chk("R2 add result", {16'd0, result}, {16'd0, r});
      chk("R4 add flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, {28'd0, f[3:0]});
   endtask

   task automatic t_sub(input logic [15:0] x, input logic [15:0] y);
      logic [15:0] r; logic [4:0] f;
      f = arith_ref(x, y, 1'b1, 1'b1, r);
      run(4'd2, x, y, 1'b0, 4'd0, 1'b0);
      chk("R3 sub result", {16'd0, result}, {16'd0, r});
      chk("R4 sub flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, {28'd0, f[3:0]});
   endtask

   task automatic t_chain(input logic [31:0] x, input logic [31:0] y, input logic sub);
      logic [31:0] got, exp;
      exp = sub ? (x - y) : (x + y);
      run(sub ? 4'd2 : 4'd0, x[15:0], y[15:0], 1'b0, 4'd0, 1'b0);
      got[15:0] = result;
      run(sub ? 4'd3 : 4'd1, x[31:16], y[31:16], flag_c, 4'd0, 1'b0);
      got[31:16] = result;
      chk(sub ? "R3 32-bit subtract chain" : "R2 32-bit add chain", got, exp);
   endtask

   task automatic t_logic(input logic [15:0] x, input logic [15:0] y);
      run(4'd4, x, y, 1'b1, 4'd0, 1'b0);
      chk("R5 and", {16'd0, result}, {16'd0, x & y});
      chk("R5 and clears c/v", {30'd0, flag_c, flag_v}, 32'd0);
      run(4'd5, x, y, 1'b0, 4'd0, 1'b0);
      chk("R5 or", {16'd0, result}, {16'd0, x | y});
      run(4'd6, x, y, 1'b0, 4'd0, 1'b0);
      chk("R5 xor", {16'd0, result}, {16'd0, x ^ y});
      run(4'd7, x, y, 1'b0, 4'd0, 1'b0);
      chk("R5 not", {16'd0, result}, {16'd0, ~x});
      run(4'd15, x, y, 1'b0, 4'd0, 1'b0);
      chk("R5 pass", {16'd0, result}, {16'd0, x});
      chk("R4 pass z/n", {30'd0, flag_z, flag_n}, {30'd0, (x == 16'd0), x[15]});
   endtask

   task automatic t_bits(input logic [15:0] x, input logic [3:0] p);
      logic [15:0] m;
      m = 16'd1 << p;
      run(4'd8, x, 16'h0, 1'b0, p, 1'b0);
      chk("R6 bit set", {16'd0, result}, {16'd0, x | m});
      run(4'd9, x, 16'h0, 1'b0, p, 1'b0);
      chk("R6 bit clear", {16'd0, result}, {16'd0, x & ~m});
      run(4'd10, x, 16'h0, 1'b0, p, 1'b0);
      chk("R6 bit toggle", {16'd0, result}, {16'd0, x ^ m});
      chk("R6 toggle c/v", {30'd0, flag_c, flag_v}, 32'd0);
   endtask

   task automatic t_test_cmp();
      logic [15:0] keep;
      run(4'd15, 16'h1234, 16'h0, 1'b0, 4'd0, 1'b0);
      keep = result;
      run(4'd11, 16'h0008, 16'h0, 1'b0, 4'd3, 1'b0);
      chk("R7 test set bit z", {31'd0, flag_z}, 32'd0);
      run(4'd11, 16'hFFF7, 16'h0, 1'b0, 4'd3, 1'b0);
      chk("R7 test clear bit z", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'h8);
      chk("R7 result kept", {16'd0, result}, {16'd0, keep});
      run(4'd12, 16'd5, 16'd5, 1'b0, 4'd0, 1'b0);
      chk("R8 cmp equal flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'hA);
      run(4'd12, 16'h8000, 16'h0001, 1'b0, 4'd0, 1'b1);
      chk("R8 cmp overflow flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'h3);
      chk("R8 result kept", {16'd0, result}, {16'd0, keep});
   endtask

   task automatic t_div(input logic [15:0] x, input logic [15:0] y);
      logic [3:0] fl;
      run(4'd5, 16'h8000, 16'h0, 1'b0, 4'd0, 1'b0);
      fl = {flag_z, flag_n, flag_c, flag_v};
      run(4'd13, x, 16'h0, 1'b0, 4'd0, 1'b0);
      for (int k = 0; k < 16; k++) run(4'd14, 16'h0, y, 1'b0, 4'd0, 1'b0);
      chk("R9 quotient", {16'd0, result}, {16'd0, x / y});
      chk("R9 remainder", {16'd0, div_rem + (div_qsign ? y : 16'd0)}, {16'd0, x % y});
      chk("R9 flags kept", {28'd0, flag_z, flag_n, flag_c, flag_v}, {28'd0, fl});
   endtask

   task automatic t_sat();
      run(4'd0, 16'h7000, 16'h2000, 1'b0, 4'd0, 1'b1);
      chk("R10 positive clamp", {16'd0, result}, 32'h7FFF);
      chk("R10 overflow flag", {31'd0, flag_v}, 32'd1);
      run(4'd2, 16'h8000, 16'h0001, 1'b0, 4'd0, 1'b1);
      chk("R10 negative clamp", {16'd0, result}, 32'h8000);
      run(4'd0, 16'h1000, 16'h2000, 1'b0, 4'd0, 1'b1);
      chk("R10 no clamp without overflow", {16'd0, result}, 32'h3000);
   endtask

   task automatic t_idle();
      logic [15:0] r0;
      run(4'd0, 16'h00FF, 16'h0001, 1'b0, 4'd0, 1'b0);
      r0 = result;
      @(negedge clk);
      op = 4'd7; a = 16'h5555; b = 16'hAAAA; op_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 idle result", {16'd0, result}, {16'd0, r0});
      chk("R11 idle flags", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'd0);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_add(16'h1234, 16'h4321);
      t_add(16'hFFFF, 16'h0001);
      t_add(16'h7FFF, 16'h0001);
      t_add(16'h8000, 16'h8000);
      t_sub(16'h0005, 16'h0007);
      t_sub(16'h8000, 16'h0001);
      t_sub(16'h4000, 16'h4000);
      t_chain(32'h0001_FFFF, 32'h0000_0001, 1'b0);
      t_chain(32'h1234_8000, 32'h0FED_9000, 1'b0);
      t_chain(32'h0001_0000, 32'h0000_0001, 1'b1);
      t_chain(32'h5000_1000, 32'h6000_2000, 1'b1);
      t_logic(16'hF0F0, 16'h3C3C);
      t_logic(16'h0000, 16'hFFFF);
      t_bits(16'h0000, 4'd0);
      t_bits(16'hA5A5, 4'd5);
      t_bits(16'h7FFF, 4'd15);
      t_test_cmp();
      t_div(16'd1000, 16'd7);
      t_div(16'hFFFF, 16'd1);
      t_div(16'hFFFF, 16'hFFFF);
      t_div(16'd5, 16'd300);
      t_div(16'hC351, 16'h00FB);
      t_sat();
      t_idle();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end
endmodule